// File: doc/BRIEF.md
# DRAM rank boundary address decoder

This block turns a physical byte address into the populated DRAM rank that holds it, the channel that serves it and the page size of that rank. Software programs eight 8-bit limit registers, four per channel, and four attribute bytes through a simple write port. Each limit is cumulative and counts in 32 MiB grains. A limit that does not rise above the limits before it marks an empty rank.

The decoder compares the two channels' limit sets. When they match pair by pair, it reports interleaved dual-channel operation. In that mode only the four channel-0 ranks are searched, and the channel follows the 128-byte line interleave bit of the address. In single-channel operation all eight ranks are searched as one cumulative chain. Ranks 4 to 7 then belong to channel 1.

A lookup is presented with a valid strobe. Its result is registered and appears on the next clock.

Top module: `rank_boundary_decoder`

## Requirements
- R1: After a synchronous active-low reset, all limits and attribute codes are zero. All result outputs read zero, `dual_mode` reads 1 because the empty channels match, and any lookup misses.
- R2: Limit registers sit at write addresses 0x00–0x03 for channel 0, ranks 0–3, and 0x80–0x83 for channel 1, ranks 4–7. Attribute bytes sit at 0x08 (ranks 0/1), 0x09 (ranks 2/3), 0x88 (ranks 4/5) and 0x89 (ranks 6/7). In each attribute byte the even rank's code is in bits 2:0 and the odd rank's code is in bits 6:4. Bits 3 and 7 are ignored, and writes to any other address have no effect.
- R3: A lookup with `lk_valid` high produces `res_valid` high with its result on the next clock. A cycle with `lk_valid` low produces `res_valid` low on the next clock.
- R4: A populated rank spans from the highest limit of all earlier ranks (zero for the first) up to its own limit times 2^25, minus one.
- R5: A rank whose limit is not above every earlier limit is empty and is never reported.
- R6: A rank whose attribute code is 000 or a reserved code (001, 101, 110, 111) is never reported. Its limit still bounds the ranks after it.
- R7: On a hit, `res_page` carries the rank's code: 010 for 4 KiB, 011 for 8 KiB, 100 for 16 KiB.
- R8: A lookup that matches no reported rank, including any address at or above the last limit, returns `res_hit`=0 with rank, channel and page all zero.
- R9: `dual_mode` is 1 exactly when each channel-0 limit equals the channel-1 limit of the same rank position. It follows register writes on the next clock.
- R10: In dual mode only ranks 0–3 are searched, and `res_chan` equals address bit 7.
- R11: In single mode ranks 0–7 form one cumulative chain, and `res_chan` is 1 exactly for ranks 4–7.
- R12: A limit of 0x80 reaches 4 GiB, so address 0x0FFFFFFFF can hit while 0x100000000 misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | 33 | Physical byte address to decode |
| res_valid | output | 1 | Result valid, one clock after the request |
| res_hit | output | 1 | Address falls in a reported rank |
| res_rank | output | 3 | Index of the hit rank |
| res_chan | output | 1 | Channel serving the address |
| res_page | output | 3 | Page-size code of the hit rank |
| dual_mode | output | 1 | Channels symmetric, interleaved operation |

## Verification
On every cycle, the assertions check these relations:
- the result strobe tracks the request strobe with a one-clock delay;
- a miss carries all-zero fields;
- a hit carries only a legal page code;
- the channel follows address bit 7 in dual mode and the rank half in single mode;
- the symmetry flag changes only after a write.

Which rank an address lands in cannot be seen by any local property. That covers cumulative spans, empty ranks by repeated limit or by attribute, the 4 GiB top, ignored reserved bits and unmapped writes. Only the bench's grain-by-grain sweeps against its arithmetic model can show these.

// File: rtl/rank_dec_pkg.sv
`timescale 1ns/1ps
// Shared constants for the rank boundary decoder: register widths,
// configuration address layout and page-size codes.
package rank_dec_pkg;
    localparam int BND_W     = 8;    // limit register width, in grains
    localparam int CODE_W    = 3;    // page-size code width
    localparam int CFG_AW    = 8;    // configuration address width
    localparam int CH_STRIDE = 128;  // address distance between channels
    localparam int ATTR_OFS  = 8;    // first attribute byte within a channel

    localparam logic [CODE_W-1:0] PG_EMPTY = 3'b000;
    localparam logic [CODE_W-1:0] PG_4K    = 3'b010;
    localparam logic [CODE_W-1:0] PG_8K    = 3'b011;
    localparam logic [CODE_W-1:0] PG_16K   = 3'b100;

    // True for the three codes that describe a usable rank.
    function automatic logic page_code_ok(input logic [CODE_W-1:0] c);
        return (c == PG_4K) || (c == PG_8K) || (c == PG_16K);
    endfunction
endpackage

// File: rtl/rank_cfg_regs.sv
`timescale 1ns/1ps
// Configuration storage: one limit byte and one page code per rank.
// Assumes two channels; channel c occupies addresses c*CH_STRIDE onward.
// Each attribute byte carries two ranks (even in [2:0], odd in [6:4]).
module rank_cfg_regs
    import rank_dec_pkg::*;
#(
    parameter  int RANKS_PER_CH = 4,
    localparam int N            = 2 * RANKS_PER_CH
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [CFG_AW-1:0]           addr,
    input  logic [BND_W-1:0]            wdata,
    output logic [N-1:0][BND_W-1:0]     bnd,
    output logic [N-1:0][CODE_W-1:0]    code
);
    for (genvar c = 0; c < 2; c++) begin : g_ch
        for (genvar r = 0; r < RANKS_PER_CH; r++) begin : g_rank
            localparam int              IDX      = c * RANKS_PER_CH + r;
            localparam logic [CFG_AW-1:0] BND_ADDR = CFG_AW'(c * CH_STRIDE + r);
            localparam logic [CFG_AW-1:0] ATR_ADDR = CFG_AW'(c * CH_STRIDE + ATTR_OFS + r / 2);
            localparam int              LSB      = (r % 2) * 4;

            logic [BND_W-1:0]  bnd_q;
            logic [CODE_W-1:0] code_q;

            // Limit register: load on a write to its own address.
            always_ff @(posedge clk) begin
                if (!rst_n)                        bnd_q <= '0;
                else if (we && addr == BND_ADDR)   bnd_q <= wdata;
            end

            // Page code: load this rank's field of the shared attribute byte.
            always_ff @(posedge clk) begin
                if (!rst_n)                        code_q <= PG_EMPTY;
                else if (we && addr == ATR_ADDR)   code_q <= wdata[LSB +: CODE_W];
            end

            assign bnd[IDX]  = bnd_q;
            assign code[IDX] = code_q;
        end
    end
endmodule

// File: rtl/rank_span_table.sv
`timescale 1ns/1ps
// Derives, from the raw limits, each rank's lower bound (running maximum
// of earlier limits), whether it is live (rises above that bound and has
// a legal page code), and whether the two channels are symmetric.
module rank_span_table
    import rank_dec_pkg::*;
#(
    parameter  int RANKS_PER_CH = 4,
    localparam int N            = 2 * RANKS_PER_CH
) (
    input  logic [N-1:0][BND_W-1:0]  bnd,
    input  logic [N-1:0][CODE_W-1:0] code,
    output logic [N-1:0][BND_W-1:0]  lo,
    output logic [N-1:0]             live,
    output logic                     dual
);
    logic [RANKS_PER_CH-1:0] pair_eq;

    for (genvar i = 0; i < N; i++) begin : g_span
        // Lower bound: zero for the first rank, else the highest earlier limit.
        if (i == 0) begin : g_first
            assign lo[i] = '0;
        end else begin : g_next
            assign lo[i] = (bnd[i-1] > lo[i-1]) ? bnd[i-1] : lo[i-1];
        end
        // A rank is live only with a non-empty span and a usable page code.
        assign live[i] = (bnd[i] > lo[i]) && page_code_ok(code[i]);
    end

    for (genvar r = 0; r < RANKS_PER_CH; r++) begin : g_sym
        // Symmetry: same-position limits of both channels agree.
        assign pair_eq[r] = (bnd[r] == bnd[r + RANKS_PER_CH]);
    end
    assign dual = &pair_eq;
endmodule

// File: rtl/rank_match.sv
`timescale 1ns/1ps
// Combinational search: finds the lowest live rank whose span holds the
// address grain. In dual mode the channel-1 half of the table is skipped.
module rank_match
    import rank_dec_pkg::*;
#(
    parameter  int RANKS_PER_CH = 4,
    localparam int N            = 2 * RANKS_PER_CH,
    localparam int RK_W         = $clog2(N)
) (
    input  logic [BND_W-1:0]         grain,
    input  logic [N-1:0][BND_W-1:0]  bnd,
    input  logic [N-1:0][BND_W-1:0]  lo,
    input  logic [N-1:0]             live,
    input  logic [N-1:0][CODE_W-1:0] code,
    input  logic                     dual,
    output logic                     hit,
    output logic [RK_W-1:0]          rank,
    output logic [CODE_W-1:0]        page
);
    logic [N-1:0] sel;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        localparam logic LOW_HALF = (i < RANKS_PER_CH);
        // Per-rank window test, gated by the mode's search range.
        assign sel[i] = live[i] && (grain >= lo[i]) && (grain < bnd[i])
                        && (dual ? LOW_HALF : 1'b1);
    end

    // Priority pick, lowest index wins (spans never overlap when live).
    always_comb begin
        hit  = 1'b0;
        rank = '0;
        page = PG_EMPTY;
        for (int i = N - 1; i >= 0; i--) begin
            if (sel[i]) begin
                hit  = 1'b1;
                rank = RK_W'(i);
                page = code[i];
            end
        end
    end
endmodule

// File: rtl/rank_boundary_decoder.sv
`timescale 1ns/1ps
// Top level: configuration registers, span derivation, window search and
// a registered result stage. Address grain is 2^GRAIN_SHIFT bytes; the
// interleave bit selects the channel in symmetric (dual) operation.
module rank_boundary_decoder
    import rank_dec_pkg::*;
#(
    parameter  int RANKS_PER_CH = 4,
    parameter  int GRAIN_SHIFT  = 25,
    parameter  int INTLV_BIT    = 7,
    localparam int N            = 2 * RANKS_PER_CH,
    localparam int RK_W         = $clog2(N),
    localparam int ADDR_W       = BND_W + GRAIN_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [BND_W-1:0]  cfg_wdata,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              res_valid,
    output logic              res_hit,
    output logic [RK_W-1:0]   res_rank,
    output logic              res_chan,
    output logic [CODE_W-1:0] res_page,
    output logic              dual_mode
);
    logic [N-1:0][BND_W-1:0]  bnd;
    logic [N-1:0][CODE_W-1:0] code;
    logic [N-1:0][BND_W-1:0]  lo;
    logic [N-1:0]             live;
    logic                     m_hit;
    logic [RK_W-1:0]          m_rank;
    logic [CODE_W-1:0]        m_page;
    logic                     take;
    logic                     chan_nxt;
    logic                     unused_low_addr;

    rank_cfg_regs #(.RANKS_PER_CH(RANKS_PER_CH)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .bnd(bnd), .code(code)
    );

    rank_span_table #(.RANKS_PER_CH(RANKS_PER_CH)) u_span (
        .bnd(bnd), .code(code), .lo(lo), .live(live), .dual(dual_mode)
    );

    rank_match #(.RANKS_PER_CH(RANKS_PER_CH)) u_match (
        .grain(lk_addr[ADDR_W-1:GRAIN_SHIFT]), .bnd(bnd), .lo(lo),
        .live(live), .code(code), .dual(dual_mode),
        .hit(m_hit), .rank(m_rank), .page(m_page)
    );

    // Low address bits only matter for the interleave select.
    assign unused_low_addr = ^lk_addr[GRAIN_SHIFT-1:0];

    // Channel: interleave bit when symmetric, else the rank's half.
    assign take     = lk_valid && m_hit;
    assign chan_nxt = dual_mode ? lk_addr[INTLV_BIT]
                                : (m_rank >= RK_W'(RANKS_PER_CH));

    // Result register: one clock of latency, zero fields on a miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_rank  <= '0;
            res_chan  <= 1'b0;
            res_page  <= PG_EMPTY;
        end else begin
            res_valid <= lk_valid;
            res_hit   <= take;
            res_rank  <= take ? m_rank : '0;
            res_chan  <= take ? chan_nxt : 1'b0;
            res_page  <= take ? m_page : PG_EMPTY;
        end
    end
endmodule

// File: rtl/rank_dec_chk.sv
`timescale 1ns/1ps
// Property checker for rank_boundary_decoder, attached by bind below.
// Checks result timing, miss/hit field shape, channel rules and the
// stability of the symmetry flag between writes.
module rank_dec_chk
    import rank_dec_pkg::*;
#(
    parameter int RANKS_PER_CH = 4,
    parameter int INTLV_BIT    = 7,
    parameter int ADDR_W       = 33,
    parameter int RK_W         = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              lk_valid,
    input logic [ADDR_W-1:0] lk_addr,
    input logic              res_valid,
    input logic              res_hit,
    input logic [RK_W-1:0]   res_rank,
    input logic              res_chan,
    input logic [CODE_W-1:0] res_page,
    input logic              dual_mode
);
    a_r3_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    a_r3_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);

    a_r8_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_rank == '0 && !res_chan && res_page == PG_EMPTY));

    a_r7_page_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit) |-> (res_page == PG_4K || res_page == PG_8K || res_page == PG_16K));

    a_r10_dual_chan: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && dual_mode) |=>
            (!res_hit || (res_rank < RK_W'(RANKS_PER_CH) && res_chan == $past(lk_addr[INTLV_BIT]))));

    a_r11_single_chan: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !dual_mode) |=>
            (!res_hit || (res_chan == (res_rank >= RK_W'(RANKS_PER_CH)))));

    a_r9_dual_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(dual_mode));
endmodule

bind rank_boundary_decoder rank_dec_chk #(
    .RANKS_PER_CH(RANKS_PER_CH), .INTLV_BIT(INTLV_BIT),
    .ADDR_W(ADDR_W), .RK_W(RK_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .lk_valid(lk_valid),
    .lk_addr(lk_addr), .res_valid(res_valid), .res_hit(res_hit),
    .res_rank(res_rank), .res_chan(res_chan), .res_page(res_page),
    .dual_mode(dual_mode)
);

// File: tb/sim_rank_boundary_decoder.sv
`timescale 1ns/1ps
// Bench: programs several rank maps and sweeps every address grain at
// three offsets, comparing against an arithmetic model of the requirements.
module sim_rank_boundary_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        lk_valid = 1'b0;
    logic [32:0] lk_addr = '0;
    logic        res_valid, res_hit, res_chan, dual_mode;
    logic [2:0]  res_rank, res_page;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [7:0] mb [8];
    logic [2:0] mc [8];

    always #2.5 clk = ~clk;

    rank_boundary_decoder u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .res_valid(res_valid), .res_hit(res_hit), .res_rank(res_rank),
        .res_chan(res_chan), .res_page(res_page), .dual_mode(dual_mode)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic code_ok(input logic [2:0] c);
        return c == 3'b010 || c == 3'b011 || c == 3'b100;
    endfunction

    function automatic logic model_dual();
        logic d = 1'b1;
        for (int r = 0; r < 4; r++) if (mb[r] != mb[r+4]) d = 1'b0;
        return d;
    endfunction

    // Expected {valid, hit, rank, chan, page} for an address.
    function automatic logic [8:0] model(input logic [32:0] a);
        logic       d    = model_dual();
        logic [7:0] prev = 8'd0;
        logic [7:0] g    = a[32:25];
        int         n    = d ? 4 : 8;
        for (int i = 0; i < n; i++) begin
            if (mb[i] > prev) begin
                if (code_ok(mc[i]) && g >= prev && g < mb[i])
                    return {1'b1, 1'b1, 3'(i), (d ? a[7] : (i >= 4)), mc[i]};
                prev = mb[i];
            end
        end
        return 9'b1_0_000_0_000;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (a)
            8'h00, 8'h01, 8'h02, 8'h03: mb[a[1:0]] = d;
            8'h80, 8'h81, 8'h82, 8'h83: mb[4 + a[1:0]] = d;
            8'h08: begin mc[0] = d[2:0]; mc[1] = d[6:4]; end
            8'h09: begin mc[2] = d[2:0]; mc[3] = d[6:4]; end
            8'h88: begin mc[4] = d[2:0]; mc[5] = d[6:4]; end
            8'h89: begin mc[6] = d[2:0]; mc[7] = d[6:4]; end
            default: ;
        endcase
    endtask

    task automatic lookup(input logic [32:0] a, output logic [8:0] got);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a;
        @(negedge clk);
        got = {res_valid, res_hit, res_rank, res_chan, res_page};
        lk_valid = 1'b0;
    endtask

    task automatic probe(input string tag, input logic [32:0] a, input logic [8:0] exp);
        logic [8:0] got;
        lookup(a, got);
        check(tag, 16'(got), 16'(exp));
    endtask

    task automatic sweep(input string tag);
        logic [8:0] got;
        logic [32:0] a;
        for (int g = 0; g < 256; g++) begin
            for (int k = 0; k < 3; k++) begin
                a = {8'(g), 25'h0} + ((k == 0) ? 33'h0 : (k == 1) ? 33'h80 : 33'h1FF_FFFF);
                lookup(a, got);
                check(tag, 16'(got), 16'(model(a)));
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin mb[i] = '0; mc[i] = '0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        check("R1 reset outputs", 16'({res_valid, res_hit, res_rank, res_chan, res_page}), 16'h0);
        check("R1 reset dual flag", 16'(dual_mode), 16'h1);
        probe("R1 empty map misses", 33'h0, 9'b1_0_000_0_000);
        @(negedge clk);
        check("R3 valid drops", 16'(res_valid), 16'h0);

        // Single-channel map, reserved attribute bits set, stray writes
        wr(8'h00, 8'd4);  wr(8'h01, 8'd4);  wr(8'h02, 8'd12); wr(8'h03, 8'd20);
        wr(8'h80, 8'd24); wr(8'h81, 8'd28); wr(8'h82, 8'd40); wr(8'h83, 8'd48);
        wr(8'h08, 8'hBA); wr(8'h09, 8'h34); wr(8'h88, 8'h52); wr(8'h89, 8'h04);
        wr(8'h04, 8'hFF); wr(8'h40, 8'hFF); wr(8'h0A, 8'hFF); wr(8'h84, 8'hFF);
        check("R9 asymmetric is single", 16'(dual_mode), 16'h0);
        probe("R2 reserved attr bits ignored", {8'd2, 25'h0}, 9'b1_1_000_0_010);
        probe("R4 last byte of rank2", {8'd12, 25'h0} - 33'd1, 9'b1_1_010_0_100);
        probe("R4 first byte of rank3", {8'd12, 25'h0}, 9'b1_1_011_0_011);
        probe("R6 reserved code rank misses", {8'd25, 25'h0}, 9'b1_0_000_0_000);
        probe("R11 rank6 on channel 1", {8'd30, 25'h80}, 9'b1_1_110_1_100);
        probe("R8 above last limit", {8'd50, 25'h0}, 9'b1_0_000_0_000);
        sweep("R4 R5 R6 R7 R11 single sweep");

        // Symmetric map: dual mode
        wr(8'h00, 8'd8); wr(8'h01, 8'd16); wr(8'h02, 8'd16); wr(8'h03, 8'd32);
        wr(8'h80, 8'd8); wr(8'h81, 8'd16); wr(8'h82, 8'd16); wr(8'h83, 8'd32);
        wr(8'h08, 8'h32); wr(8'h09, 8'h24);
        check("R9 symmetric is dual", 16'(dual_mode), 16'h1);
        probe("R10 interleave bit set", {8'd3, 25'h80}, 9'b1_1_000_1_010);
        probe("R10 interleave bit clear", {8'd3, 25'h0}, 9'b1_1_000_0_010);
        probe("R5 repeated limit skipped", {8'd20, 25'h0}, 9'b1_1_011_0_010);
        probe("R8 beyond dual top", {8'd40, 25'h0}, 9'b1_0_000_0_000);
        sweep("R10 dual sweep");
        wr(8'h82, 8'd17);
        check("R9 one mismatch leaves dual", 16'(dual_mode), 16'h0);
        sweep("R9 R11 asymmetric sweep");

        // 4 GiB top
        wr(8'h00, 8'h40); wr(8'h01, 8'h80); wr(8'h02, 8'h80); wr(8'h03, 8'h80);
        wr(8'h80, 8'h80); wr(8'h81, 8'h80); wr(8'h82, 8'h80); wr(8'h83, 8'h80);
        wr(8'h08, 8'h34);
        probe("R12 last byte below 4 GiB", 33'h0_FFFF_FFFF, 9'b1_1_001_0_011);
        probe("R12 at 4 GiB misses", 33'h1_0000_0000, 9'b1_0_000_0_000);
        probe("R12 top of rank0", 33'h0_7FFF_FFFF, 9'b1_1_000_0_100);
        sweep("R12 sweep");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule